// File: doc/BRIEF.md
# Time-Stamp Event Capture Unit

This block keeps a free-running 32-bit time-stamp counter. It records the counter value whenever an event source fires. Each record carries an event-kind code and a source index, and the records go into a show-ahead event queue that a host drains one entry at a time. The upper bits of the host's timeline are kept outside the block. The counter itself emits a marker whenever it crosses its midpoint or wraps, so software can extend the 32-bit value.

There are four kinds of event source:
- a software push strobe, which lets the host sample the timer;
- eight hardware push inputs, which are synchronised and edge-detected;
- a packet path, which takes its stamp when the start-of-frame delimiter passes but queues it only after a later validation strobe;
- the counter's own wrap and midpoint markers.

Packet validation is late, so a wrap marker can land in the queue ahead of a stamp taken before the wrap. The stamp's most significant bit then tells the reader on which side of the wrap the packet was stamped.

Each source has a one-entry pending slot. A fixed-priority arbiter moves one slot per cycle into the queue. A record that finds its slot still occupied, or finds the queue full, is discarded and sets a sticky overflow flag. A load port sets the counter to any value.

Top module: `ts_event_unit`

## Requirements
- R1: After reset the counter holds CNT_INIT (default 0) and increases by one every clock. When ts_load_i is high, the counter takes ts_load_val_i at the next edge and counts on from there.
- R2: When the counter goes from 0xFFFF_FFFF to 0x0000_0000 without a load, a record is queued with kind 1, index 0 and stamp 0x0000_0000.
- R3: When the counter goes from 0x7FFF_FFFF to 0x8000_0000 without a load, a record is queued with kind 2, index 0 and stamp 0x8000_0000.
- R4: A cycle with sw_push_i high queues a record with kind 0, index 0 and, as its stamp, the counter value of that cycle.
- R5: Each rising edge on hw_push_i[n] queues exactly one record with kind 3 and index n+1, however long the input stays high. Its stamp is the counter value two cycles after the edge is driven.
- R6: pkt_sof_i captures the counter, the direction and pkt_port_i. A later pkt_vld_i queues that capture with kind 4 (receive, pkt_tx_i low) or kind 5 (transmit) and with the port as its index. pkt_bad_i discards the capture. pkt_vld_i with no capture pending queues nothing.
- R7: If the counter wraps between a packet's start of frame and its validation, the wrap record comes out of the queue before the packet record. The packet record keeps its pre-wrap stamp.
- R8: Records taken in the same cycle leave the queue in this order: wrap, midpoint, packet, software push, then hardware inputs 1 to 8.
- R9: When the queue (FIFO_DEPTH, default 8) is full, new records are discarded, the records already stored are kept, and ovf_o goes high. ovf_o stays high until ovf_clr_i is pulsed.
- R10: After reset ev_valid_o and ovf_o are low.
- R11: While ev_valid_o is high, the ev_* outputs show the oldest record and stay steady until ev_rd_i removes it at a clock edge. Records leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ts_load_i | input | 1 | Load the counter |
| ts_load_val_i | input | 32 | Value to load |
| sw_push_i | input | 1 | Software push strobe |
| hw_push_i | input | HW_N | Asynchronous hardware push inputs |
| pkt_sof_i | input | 1 | Start-of-frame strobe, captures the stamp |
| pkt_tx_i | input | 1 | Direction of the frame, 1 = transmit |
| pkt_port_i | input | PORT_W | Port number of the frame |
| pkt_vld_i | input | 1 | Frame confirmed as a timing packet |
| pkt_bad_i | input | 1 | Frame rejected, drop the capture |
| ev_rd_i | input | 1 | Remove the head record |
| ev_valid_o | output | 1 | Queue not empty |
| ev_kind_o | output | 4 | Kind code of the head record |
| ev_idx_o | output | 4 | Source index of the head record |
| ev_stamp_o | output | 32 | Captured counter value of the head record |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Clear the overflow flag |

## Verification
Two cases are the hardest to reach from the ports:
- a wrap falling between a packet's capture and its validation;
- a wrap, a packet validation, a software push and a hardware edge all arriving in the same cycle.

A natural wrap is four billion cycles away. The stimulus therefore loads the counter a few counts below 0xFFFF_FFFF or 0x7FFF_FFFF, and for the combined case it drives the hardware input two cycles ahead of the others so that its synchroniser delay lines it up with the wrap. The reference model follows the counter from reset and loads alone. It queues a wrap or midpoint expectation on the cycle its own copy of the count crosses over.

// File: rtl/ts_event_pkg.sv
package ts_event_pkg;
  localparam int TS_W  = 32;
  localparam int IDX_W = 4;

  typedef enum logic [3:0] {
    EV_SW   = 4'd0,
    EV_ROLL = 4'd1,
    EV_HALF = 4'd2,
    EV_HW   = 4'd3,
    EV_RX   = 4'd4,
    EV_TX   = 4'd5
  } ev_kind_e;

  typedef struct packed {
    ev_kind_e         kind;
    logic [IDX_W-1:0] idx;
    logic [TS_W-1:0]  stamp;
  } ev_rec_t;

  // fixed slot positions, lower index wins arbitration
  localparam int SLOT_ROLL = 0;
  localparam int SLOT_HALF = 1;
  localparam int SLOT_PKT  = 2;
  localparam int SLOT_SW   = 3;
  localparam int SLOT_HW0  = 4;
endpackage

// File: rtl/ts_counter.sv
module ts_counter
  import ts_event_pkg::*;
#(
  parameter logic [TS_W-1:0] CNT_INIT = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [TS_W-1:0] load_val_i,
  output logic [TS_W-1:0] cnt_o,
  output logic            wrap_o,
  output logic            half_o
);
  localparam logic [TS_W-1:0] ALL_ONES = '1;
  localparam logic [TS_W-1:0] HALF_M1  = {1'b0, {(TS_W-1){1'b1}}};

  logic [TS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CNT_INIT;
    else if (load_i) cnt_q <= load_val_i;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = !load_i && (cnt_q == ALL_ONES);
  assign half_o = !load_i && (cnt_q == HALF_M1);
endmodule

// File: rtl/ts_push_sync.sv
module ts_push_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] sync_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= in_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ts_pkt_hold.sv
module ts_pkt_hold
  import ts_event_pkg::*;
#(
  parameter int PORT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              tx_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              vld_i,
  input  logic              bad_i,
  input  logic [TS_W-1:0]   cnt_i,
  output logic              fire_o,
  output ev_rec_t           rec_o
);
  logic    held_q;
  ev_rec_t rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      rec_q  <= '0;
    end else if (sof_i) begin
      held_q <= 1'b1;
      rec_q  <= '{kind: (tx_i ? EV_TX : EV_RX), idx: IDX_W'(port_i), stamp: cnt_i};
    end else if (vld_i || bad_i) begin
      held_q <= 1'b0;
    end
  end

  // the verdict always refers to the capture already held
  assign fire_o = vld_i && held_q;
  assign rec_o  = rec_q;
endmodule

// File: rtl/ts_src_slots.sv
module ts_src_slots
  import ts_event_pkg::*;
#(
  parameter int NSRC = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] fire_i,
  input  ev_rec_t         rec_i [NSRC],
  output logic [NSRC-1:0] gnt_o,
  output logic            vld_o,
  output ev_rec_t         rec_o,
  output logic            drop_o
);
  logic [NSRC-1:0] pend_q;
  ev_rec_t         hold_q [NSRC];

  always_comb begin
    gnt_o = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend_q[i] && gnt_o == '0) gnt_o[i] = 1'b1;
  end

  always_comb begin
    rec_o = '0;
    for (int i = 0; i < NSRC; i++)
      if (gnt_o[i]) rec_o = hold_q[i];
  end

  assign vld_o  = |pend_q;
  assign drop_o = |(fire_i & pend_q & ~gnt_o);

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[g] <= 1'b0;
        hold_q[g] <= '0;
      end else if (fire_i[g] && (!pend_q[g] || gnt_o[g])) begin
        pend_q[g] <= 1'b1;
        hold_q[g] <= rec_i[g];
      end else if (gnt_o[g]) begin
        pend_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ts_event_fifo.sv
module ts_event_fifo
  import ts_event_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_i,
  input  ev_rec_t wr_rec_i,
  input  logic    rd_i,
  output logic    full_o,
  output logic    vld_o,
  output ev_rec_t rec_o
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0] wp_q, rp_q;
  ev_rec_t     mem_q [DEPTH];
  logic        empty, do_wr, do_rd;

  assign empty  = (wp_q == rp_q);
  assign full_o = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_wr  = wr_i && !full_o;
  assign do_rd  = rd_i && !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (do_wr) wp_q <= wp_q + 1'b1;
      if (do_rd) rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wp_q[AW-1:0]] <= wr_rec_i;
  end

  assign vld_o = !empty;
  assign rec_o = mem_q[rp_q[AW-1:0]];
endmodule

// File: rtl/ts_event_unit.sv
module ts_event_unit
  import ts_event_pkg::*;
#(
  parameter int               HW_N       = 8,
  parameter int               PORT_W     = 2,
  parameter int               FIFO_DEPTH = 8,
  parameter int               SYNC_STG   = 2,
  parameter logic [TS_W-1:0]  CNT_INIT   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ts_load_i,
  input  logic [31:0]       ts_load_val_i,
  input  logic              sw_push_i,
  input  logic [HW_N-1:0]   hw_push_i,
  input  logic              pkt_sof_i,
  input  logic              pkt_tx_i,
  input  logic [PORT_W-1:0] pkt_port_i,
  input  logic              pkt_vld_i,
  input  logic              pkt_bad_i,
  input  logic              ev_rd_i,
  output logic              ev_valid_o,
  output logic [3:0]        ev_kind_o,
  output logic [3:0]        ev_idx_o,
  output logic [31:0]       ev_stamp_o,
  output logic              ovf_o,
  input  logic              ovf_clr_i
);
  localparam int NSRC = SLOT_HW0 + HW_N;
  localparam logic [TS_W-1:0] HALF_STAMP = {1'b1, {(TS_W-1){1'b0}}};

  logic [TS_W-1:0] ts_cnt;
  logic            ts_wrap, ts_half;
  logic [HW_N-1:0] hw_rise;
  logic            pkt_fire;
  ev_rec_t         pkt_rec;
  logic [NSRC-1:0] src_fire;
  ev_rec_t         src_rec [NSRC];
  logic [NSRC-1:0] slot_gnt;
  logic            slot_vld, slot_drop;
  ev_rec_t         slot_rec;
  logic            fifo_full, fifo_vld;
  ev_rec_t         fifo_rec;
  logic            ovf_q;

  ts_counter #(.CNT_INIT(CNT_INIT)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ts_load_i),
    .load_val_i (ts_load_val_i),
    .cnt_o      (ts_cnt),
    .wrap_o     (ts_wrap),
    .half_o     (ts_half)
  );

  ts_push_sync #(.N(HW_N), .STAGES(SYNC_STG)) u_hw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (hw_push_i),
    .rise_o (hw_rise)
  );

  ts_pkt_hold #(.PORT_W(PORT_W)) u_pkt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sof_i  (pkt_sof_i),
    .tx_i   (pkt_tx_i),
    .port_i (pkt_port_i),
    .vld_i  (pkt_vld_i),
    .bad_i  (pkt_bad_i),
    .cnt_i  (ts_cnt),
    .fire_o (pkt_fire),
    .rec_o  (pkt_rec)
  );

  // wrap markers carry the value the counter takes at the crossing
  assign src_fire[SLOT_ROLL] = ts_wrap;
  assign src_rec[SLOT_ROLL]  = '{kind: EV_ROLL, idx: '0, stamp: '0};
  assign src_fire[SLOT_HALF] = ts_half;
  assign src_rec[SLOT_HALF]  = '{kind: EV_HALF, idx: '0, stamp: HALF_STAMP};
  assign src_fire[SLOT_PKT]  = pkt_fire;
  assign src_rec[SLOT_PKT]   = pkt_rec;
  assign src_fire[SLOT_SW]   = sw_push_i;
  assign src_rec[SLOT_SW]    = '{kind: EV_SW, idx: '0, stamp: ts_cnt};

  for (genvar g = 0; g < HW_N; g++) begin : g_hw
    assign src_fire[SLOT_HW0+g] = hw_rise[g];
    assign src_rec[SLOT_HW0+g]  = '{kind: EV_HW, idx: IDX_W'(g + 1), stamp: ts_cnt};
  end

  ts_src_slots #(.NSRC(NSRC)) u_slots (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (src_fire),
    .rec_i  (src_rec),
    .gnt_o  (slot_gnt),
    .vld_o  (slot_vld),
    .rec_o  (slot_rec),
    .drop_o (slot_drop)
  );

  ts_event_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (slot_vld),
    .wr_rec_i (slot_rec),
    .rd_i     (ev_rd_i),
    .full_o   (fifo_full),
    .vld_o    (fifo_vld),
    .rec_o    (fifo_rec)
  );

  // a new loss outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ovf_q <= 1'b0;
    else if (slot_drop || (slot_vld && fifo_full)) ovf_q <= 1'b1;
    else if (ovf_clr_i)                         ovf_q <= 1'b0;
  end

  assign ev_valid_o = fifo_vld;
  assign ev_kind_o  = fifo_rec.kind;
  assign ev_idx_o   = fifo_rec.idx;
  assign ev_stamp_o = fifo_rec.stamp;
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/ts_event_chk.sv
module ts_event_chk #(
  parameter int NSRC = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ts_load_i,
  input logic [31:0]     ts_load_val_i,
  input logic [31:0]     ts_cnt,
  input logic [NSRC-1:0] slot_gnt,
  input logic            slot_vld,
  input logic            fifo_full,
  input logic            ev_valid_o,
  input logic            ev_rd_i,
  input logic [31:0]     ev_stamp_o,
  input logic            ovf_o,
  input logic            ovf_clr_i
);
  p_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_load_i |=> ts_cnt == $past(ts_cnt) + 32'd1);

  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_load_i |=> ts_cnt == $past(ts_load_val_i));

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ts_load_i && ts_cnt == 32'hFFFF_FFFF) |=> ts_cnt == 32'h0);

  p_one_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_gnt));

  p_grant_when_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_vld |-> $countones(slot_gnt) == 1);

  p_ovf_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld && fifo_full) |=> ovf_o);

  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  p_head_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_o && !ev_rd_i) |=> (ev_valid_o && $stable(ev_stamp_o)));
endmodule

bind ts_event_unit ts_event_chk #(.NSRC(NSRC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ts_load_i     (ts_load_i),
  .ts_load_val_i (ts_load_val_i),
  .ts_cnt        (ts_cnt),
  .slot_gnt      (slot_gnt),
  .slot_vld      (slot_vld),
  .fifo_full     (fifo_full),
  .ev_valid_o    (ev_valid_o),
  .ev_rd_i       (ev_rd_i),
  .ev_stamp_o    (ev_stamp_o),
  .ovf_o         (ovf_o),
  .ovf_clr_i     (ovf_clr_i)
);

// File: tb/ts_event_unit_test.sv
`timescale 1ns/1ps
module ts_event_unit_test;
  localparam int HW_N = 8;
  localparam int PORT_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ts_load = 1'b0;
  logic [31:0]       ts_load_val = '0;
  logic              sw_push = 1'b0;
  logic [HW_N-1:0]   hw_push = '0;
  logic              pkt_sof = 1'b0, pkt_tx = 1'b0, pkt_vld = 1'b0, pkt_bad = 1'b0;
  logic [PORT_W-1:0] pkt_port = '0;
  logic              ev_rd = 1'b0;
  logic              ev_valid, ovf, ovf_clr = 1'b0;
  logic [3:0]        ev_kind, ev_idx;
  logic [31:0]       ev_stamp;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit mon_en = 1'b1;
  logic [31:0] model_cnt;
  logic [39:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ts_event_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .ts_load_i(ts_load), .ts_load_val_i(ts_load_val),
    .sw_push_i(sw_push), .hw_push_i(hw_push), .pkt_sof_i(pkt_sof), .pkt_tx_i(pkt_tx),
    .pkt_port_i(pkt_port), .pkt_vld_i(pkt_vld), .pkt_bad_i(pkt_bad), .ev_rd_i(ev_rd),
    .ev_valid_o(ev_valid), .ev_kind_o(ev_kind), .ev_idx_o(ev_idx), .ev_stamp_o(ev_stamp),
    .ovf_o(ovf), .ovf_clr_i(ovf_clr)
  );

  // counter model from R1
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       model_cnt <= 32'h0;
    else if (ts_load) model_cnt <= ts_load_val;
    else              model_cnt <= model_cnt + 32'd1;
  end

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [3:0] kind, input logic [3:0] idx, input logic [31:0] stamp, input string tag);
    exp_q.push_back({kind, idx, stamp});
    tag_q.push_back(tag);
  endtask

  // one cycle: release strobes, queue wrap/midpoint expectations (R2, R3)
  task automatic tick();
    @(negedge clk);
    sw_push = 1'b0; pkt_sof = 1'b0; pkt_vld = 1'b0; pkt_bad = 1'b0;
    ts_load = 1'b0; ovf_clr = 1'b0;
    if (rst_n && model_cnt == 32'hFFFF_FFFF) expect_ev(4'd1, 4'd0, 32'h0, "R2 wrap");
    if (rst_n && model_cnt == 32'h7FFF_FFFF) expect_ev(4'd2, 4'd0, 32'h8000_0000, "R3 midpoint");
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((exp_q.size() != 0 || ev_valid) && n < 200) begin
      tick();
      n++;
    end
    repeat (3) tick();
    check(exp_q.size() == 0 && !ev_valid, tag, 40'(exp_q.size()), 40'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n || !mon_en) ev_rd <= 1'b0;
    else if (ev_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected record", {ev_kind, ev_idx, ev_stamp}, 40'h0);
      end else begin
        logic [39:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({ev_kind, ev_idx, ev_stamp} == e, t, {ev_kind, ev_idx, ev_stamp}, e);
      end
      ev_rd <= 1'b1;
    end else ev_rd <= 1'b0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    check(!ev_valid, "R10 valid after reset", 40'(ev_valid), 40'd0);
    check(!ovf, "R10 ovf after reset", 40'(ovf), 40'd0);

    // R4 software push
    tick(); sw_push = 1'b1; expect_ev(4'd0, 4'd0, model_cnt, "R4 sw push");
    drain("R4 drain");

    // R1 load and count
    tick(); ts_load = 1'b1; ts_load_val = 32'h1234_5678;
    tick(); sw_push = 1'b1; expect_ev(4'd0, 4'd0, 32'h1234_5678, "R1 load value");
    repeat (4) tick();
    sw_push = 1'b1; expect_ev(4'd0, 4'd0, 32'h1234_567C, "R1 counting");
    drain("R1 drain");

    // R5 held input gives one record, then another input
    tick(); hw_push[0] = 1'b1; expect_ev(4'd3, 4'd1, model_cnt + 32'd2, "R5 hw1 held");
    repeat (10) tick();
    hw_push[0] = 1'b0;
    tick(); hw_push[4] = 1'b1; expect_ev(4'd3, 4'd5, model_cnt + 32'd2, "R5 hw5");
    repeat (3) tick();
    hw_push[4] = 1'b0;
    drain("R5 drain");
    tick(); hw_push[7] = 1'b1; hw_push[0] = 1'b1;
    expect_ev(4'd3, 4'd1, model_cnt + 32'd2, "R8 hw1 before hw8");
    expect_ev(4'd3, 4'd8, model_cnt + 32'd2, "R8 hw8 after hw1");
    repeat (3) tick();
    hw_push = '0;
    drain("R8 hw drain");

    // R6 packet path
    tick(); pkt_sof = 1'b1; pkt_tx = 1'b0; pkt_port = 2'd2; s = model_cnt;
    repeat (3) tick();
    pkt_vld = 1'b1; expect_ev(4'd4, 4'd2, s, "R6 rx packet");
    tick(); pkt_sof = 1'b1; pkt_tx = 1'b1; pkt_port = 2'd1; s = model_cnt;
    tick(); pkt_vld = 1'b1; expect_ev(4'd5, 4'd1, s, "R6 tx packet");
    drain("R6 drain");
    tick(); pkt_sof = 1'b1;
    tick(); pkt_bad = 1'b1;
    repeat (6) tick();
    check(!ev_valid, "R6 rejected packet queued", 40'(ev_valid), 40'd0);
    pkt_vld = 1'b1;
    repeat (6) tick();
    check(!ev_valid, "R6 orphan valid queued", 40'(ev_valid), 40'd0);

    // R3 midpoint
    tick(); ts_load = 1'b1; ts_load_val = 32'h7FFF_FFF8;
    repeat (15) tick();
    drain("R3 drain");

    // R7 late validation across a wrap (R2 marker queued by tick)
    tick(); ts_load = 1'b1; ts_load_val = 32'hFFFF_FFF0;
    tick(); pkt_sof = 1'b1; pkt_tx = 1'b0; pkt_port = 2'd0; s = model_cnt;
    repeat (20) tick();
    pkt_vld = 1'b1; expect_ev(4'd4, 4'd0, s, "R7 late packet after wrap");
    drain("R7 drain");

    // R8 wrap, packet, sw and hw3 in one cycle
    tick(); pkt_sof = 1'b1; pkt_tx = 1'b1; pkt_port = 2'd3; s = model_cnt;
    tick(); ts_load = 1'b1; ts_load_val = 32'hFFFF_FFFD;
    tick(); hw_push[2] = 1'b1;
    tick();
    tick();
    check(model_cnt == 32'hFFFF_FFFF, "R8 setup", 40'(model_cnt), 40'hFFFF_FFFF);
    sw_push = 1'b1; pkt_vld = 1'b1;
    expect_ev(4'd5, 4'd3, s, "R8 packet after wrap");
    expect_ev(4'd0, 4'd0, 32'hFFFF_FFFF, "R8 sw after packet");
    expect_ev(4'd3, 4'd3, 32'hFFFF_FFFF, "R8 hw3 last");
    repeat (3) tick();
    hw_push = '0;
    drain("R8 drain");

    // R9 overflow
    mon_en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick(); sw_push = 1'b1;
      if (i < 8) expect_ev(4'd0, 4'd0, model_cnt, "R9 kept record");
    end
    repeat (5) tick();
    check(ovf, "R9 ovf set", 40'(ovf), 40'd1);
    mon_en = 1'b1;
    drain("R9 drain");
    check(ovf, "R9 ovf sticky", 40'(ovf), 40'd1);
    tick(); ovf_clr = 1'b1;
    tick();
    tick();
    check(!ovf, "R9 ovf cleared", 40'(ovf), 40'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule